// File: doc/BRIEF.md
# Triplicated-Storage I2C Register Bank

This block is an I2C target that gives a host access to a small, parameterised set of byte-wide locations. Every location couples two things. The first is an inbound configuration byte that the host writes and the chip consumes on a parallel output. The second is an outbound status byte that the chip supplies on a parallel input and the host reads back. Typical use is slow-control of a detector front end, where the configuration must survive single-event upsets.

Each inbound byte is kept in three copies. Its output is the bitwise majority of those copies. On every system clock the voted value is written back into all three copies. A single upset is therefore corrected before a second upset can reach another copy of the same bit. A write over the bus loads all three copies at once. SCL and SDA are oversampled in the system clock domain. The target never drives SCL, and it pulls SDA low through an enable output. An upset-injection input lets test logic flip individual stored bits.

A host writes in two stages. It first sends a register-address byte, and that byte sets an internal pointer. Reads then start from that pointer. When a register-address byte is out of range, the target refuses it and ignores the data that follows.

Top module: `tmr_i2c_regbank`

## Requirements
- R1: While reset is asserted and after reset is released, every inbound byte equals `RESET_VAL` (default 0x00), and `sdaOutEn` is 0.
- R2: The target acknowledges only a first byte whose upper seven bits equal `DEV_ADDR`. A transaction that carries any other device address gets no acknowledge on any byte and changes no inbound byte.
- R3: In a write transaction, the byte after the device address is the register address and sets the pointer. Each later byte is stored at the pointer and is acknowledged. The pointer then advances by one, and it wraps from `NUM_REGS-1` to 0.
- R4: A register-address byte of `NUM_REGS` or more is not acknowledged. The data bytes that follow it in the same transaction are neither acknowledged nor stored, and the pointer keeps its previous value.
- R5: A device address with bit 0 set to 1 starts a read. Each byte returned is `outboundData[8*ptr +: 8]`, sent MSB first, and the pointer advances with the same wrap after every byte. The target continues while the host acknowledges. After a host not-acknowledge it releases SDA.
- R6: Flipping one copy of any stored bit (`flipMask` bit index `(copy*NUM_REGS + reg)*8 + bit`, applied for one clock) leaves every inbound output unchanged.
- R7: One clock after a single-copy upset, all three copies agree again. A second upset on a different copy of the same bit, one or more clocks later, also leaves the output unchanged.
- R8: `sdaOutEn` changes only while SCL is low, never while SCL is high.
- R9: A repeated START after the register-address byte starts a new address phase. The pointer set before the repeated START is kept, so the read that follows begins at that location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which also oversamples the bus |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | SCL line level |
| sdaIn | input | 1 | SDA line level |
| sdaOutEn | output | 1 | When 1, the target pulls SDA low |
| outboundData | input | 8*NUM_REGS | On-chip status bytes that reads return, location n in bits [8n+7:8n] |
| inboundData | output | 8*NUM_REGS | Voted configuration bytes, location n in bits [8n+7:8n] |
| flipMask | input | 24*NUM_REGS | One-clock XOR into the stored copies, bit (copy*NUM_REGS+reg)*8+bit |

## Verification
The hardest case to create from the ports is an upset that accumulates. Two different copies of the same bit must be hit in separate clocks, and the bench must then show that scrubbing closed the window between the two hits. To do this, the bench pulses `flipMask` on one copy on a falling clock edge. It lets one rising edge pass, then hits a second copy of the same bit. It compares the voted output with its own model after each edge, and it sweeps every location, copy and bit. The I2C side also has a delicate case: a repeated START placed between the pointer write and the read. The bench covers it with read-back sweeps that wrap the pointer.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;

  typedef struct packed {
    logic       ptrLoad;
    logic       ptrInc;
    logic       wrEn;
    logic [7:0] byteVal;
  } rbStrobe_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_REG,
    ST_REG_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } rbState_t;

  function automatic logic [7:0] maj3(input logic [7:0] a, input logic [7:0] b,
                                      input logic [7:0] c);
    return (a & b) | (b & c) | (a & c);
  endfunction

endpackage

// File: rtl/i2c_rb_linesync.sv
module i2c_rb_linesync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineIn,
  output logic lineS,
  output logic linePrev
);

  logic [STAGES:0] pipe;

  always_ff @(posedge clk) begin
    if (!rstN) pipe <= '1;
    else       pipe <= {pipe[STAGES-1:0], lineIn};
  end

  assign lineS    = pipe[STAGES-1];
  assign linePrev = pipe[STAGES];

endmodule

// File: rtl/i2c_rb_tmr_byte.sv
module i2c_rb_tmr_byte import i2c_rb_pkg::*; #(
  parameter logic [7:0] RESET_VAL = 8'h00
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            wrEn,
  input  logic [7:0]      wrData,
  input  logic [2:0][7:0] flip,
  output logic [7:0]      voted
);

  logic [2:0][7:0] copyQ;
  logic            copiesAgree;
  logic            singleFlip;

  assign voted       = maj3(copyQ[0], copyQ[1], copyQ[2]);
  assign copiesAgree = (copyQ[0] == copyQ[1]) && (copyQ[1] == copyQ[2]);
  assign singleFlip  = ((flip[0] & flip[1]) | (flip[1] & flip[2]) | (flip[0] & flip[2])) == 8'h00;

  always_ff @(posedge clk) begin
    for (int k = 0; k < 3; k++) begin
      if (!rstN)     copyQ[k] <= RESET_VAL;
      else if (wrEn) copyQ[k] <= wrData ^ flip[k];
      else           copyQ[k] <= voted ^ flip[k];
    end
  end

  // R7
  scrub_heal_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(flip) == '0) |-> copiesAgree);

  // R6
  single_upset_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(wrEn) && $past(copiesAgree) && $past(singleFlip))
      |-> voted == $past(voted));

  // R3
  write_all_copies_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && singleFlip) |=> voted == $past(wrData));

endmodule

// File: rtl/i2c_rb_datapath.sv
module i2c_rb_datapath import i2c_rb_pkg::*; #(
  parameter int         NUM_REGS  = 3,
  parameter logic [7:0] RESET_VAL = 8'h00
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  rbStrobe_t               strb,
  input  logic [NUM_REGS*24-1:0]  flipMask,
  input  logic [NUM_REGS*8-1:0]   outboundData,
  output logic [NUM_REGS*8-1:0]   inboundData,
  output logic [7:0]              rdByte
);

  localparam int PTR_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_REGS - 1);

  logic [PTR_W-1:0]           ptr;
  logic [NUM_REGS-1:0][7:0]   regVal;
  logic [NUM_REGS-1:0][7:0]   obArr;

  always_ff @(posedge clk) begin
    if (!rstN)             ptr <= '0;
    else if (strb.ptrLoad) ptr <= strb.byteVal[PTR_W-1:0];
    else if (strb.ptrInc)  ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end

  genvar g, k;
  generate
    for (g = 0; g < NUM_REGS; g++) begin : gReg
      logic [2:0][7:0] flipSlice;
      for (k = 0; k < 3; k++) begin : gCopy
        assign flipSlice[k] = flipMask[(k*NUM_REGS + g)*8 +: 8];
      end
      i2c_rb_tmr_byte #(.RESET_VAL(RESET_VAL)) u_store (
        .clk    (clk),
        .rstN   (rstN),
        .wrEn   (strb.wrEn && (ptr == PTR_W'(g))),
        .wrData (strb.byteVal),
        .flip   (flipSlice),
        .voted  (regVal[g])
      );
    end
  endgenerate

  assign inboundData = regVal;
  assign obArr       = outboundData;
  assign rdByte      = obArr[ptr];

  // R3
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    ptr <= LAST);

endmodule

// File: rtl/i2c_rb_ctrl.sv
module i2c_rb_ctrl import i2c_rb_pkg::*; #(
  parameter int         NUM_REGS = 3,
  parameter logic [6:0] DEV_ADDR = 7'h52
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclS,
  input  logic       sclPrev,
  input  logic       sdaS,
  input  logic       sdaPrev,
  input  logic [7:0] rdByte,
  output rbStrobe_t  strb,
  output logic       sdaOe
);

  localparam logic [8:0] REG_COUNT = 9'(NUM_REGS);

  rbState_t   state;
  logic [2:0] bitCnt;
  logic [6:0] shiftR;
  logic [7:0] txShift;
  logic       ackPend;
  logic       ackGood;
  logic       ackDrv;
  logic       rwBit;
  logic       masterAck;

  logic       sclRise, sclFall, startC, stopC, inRange;
  logic [7:0] rxByte;

  assign sclRise = sclS & ~sclPrev;
  assign sclFall = ~sclS & sclPrev;
  assign startC  = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopC   = sclS & sclPrev & ~sdaPrev & sdaS;
  assign rxByte  = {shiftR, sdaS};
  assign inRange = {1'b0, rxByte} < REG_COUNT;
  assign sdaOe   = ackDrv | ((state == ST_RD) & ~txShift[7]);

  always_comb begin
    strb         = '0;
    strb.byteVal = rxByte;
    if (!startC && !stopC) begin
      if (sclRise && bitCnt == 3'd7) begin
        if (state == ST_REG && inRange) strb.ptrLoad = 1'b1;
        if (state == ST_WR) begin
          strb.wrEn   = 1'b1;
          strb.ptrInc = 1'b1;
        end
      end
      if (sclFall && state == ST_RD && bitCnt == 3'd7) strb.ptrInc = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      shiftR    <= '0;
      txShift   <= '1;
      ackPend   <= 1'b0;
      ackGood   <= 1'b0;
      ackDrv    <= 1'b0;
      rwBit     <= 1'b0;
      masterAck <= 1'b0;
    end else if (startC) begin
      state   <= ST_DEV;
      bitCnt  <= '0;
      ackPend <= 1'b0;
      ackDrv  <= 1'b0;
    end else if (stopC) begin
      state   <= ST_IDLE;
      ackPend <= 1'b0;
      ackDrv  <= 1'b0;
    end else begin
      case (state)
        ST_DEV, ST_REG, ST_WR: begin
          if (sclRise) begin
            shiftR <= rxByte[6:0];
            bitCnt <= bitCnt + 3'd1;
            if (bitCnt == 3'd7) begin
              ackPend <= 1'b0;
              if (state == ST_DEV) begin
                if (rxByte[7:1] == DEV_ADDR) begin
                  state   <= ST_DEV_ACK;
                  rwBit   <= rxByte[0];
                  ackGood <= 1'b1;
                end else begin
                  state <= ST_IDLE;
                end
              end else if (state == ST_REG) begin
                state   <= ST_REG_ACK;
                ackGood <= inRange;
              end else begin
                state   <= ST_WR_ACK;
                ackGood <= 1'b1;
              end
            end
          end
        end
        ST_DEV_ACK, ST_REG_ACK, ST_WR_ACK: begin
          if (sclFall) begin
            if (!ackPend) begin
              ackPend <= 1'b1;
              ackDrv  <= ackGood;
            end else begin
              ackPend <= 1'b0;
              ackDrv  <= 1'b0;
              bitCnt  <= '0;
              if (state == ST_DEV_ACK) begin
                if (rwBit) begin
                  state   <= ST_RD;
                  txShift <= rdByte;
                end else begin
                  state <= ST_REG;
                end
              end else if (state == ST_REG_ACK) begin
                state <= ackGood ? ST_WR : ST_IDLE;
              end else begin
                state <= ST_WR;
              end
            end
          end
        end
        ST_RD: begin
          if (sclFall) begin
            if (bitCnt == 3'd7) begin
              bitCnt  <= '0;
              txShift <= '1;
              state   <= ST_RD_ACK;
            end else begin
              bitCnt  <= bitCnt + 3'd1;
              txShift <= {txShift[6:0], 1'b1};
            end
          end
        end
        ST_RD_ACK: begin
          if (sclRise) masterAck <= ~sdaS;
          if (sclFall) begin
            if (masterAck) begin
              state   <= ST_RD;
              txShift <= rdByte;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8
  sda_low_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !$past(sclS));

  // R8
  sda_release_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(sdaOe) && !$past(startC) && !$past(stopC)) |-> !$past(sclS));

endmodule

// File: rtl/tmr_i2c_regbank.sv
module tmr_i2c_regbank import i2c_rb_pkg::*; #(
  parameter int         NUM_REGS  = 3,
  parameter logic [6:0] DEV_ADDR  = 7'h52,
  parameter logic [7:0] RESET_VAL = 8'h00,
  parameter int         SYNC_LEN  = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   sclIn,
  input  logic                   sdaIn,
  output logic                   sdaOutEn,
  input  logic [NUM_REGS*8-1:0]  outboundData,
  output logic [NUM_REGS*8-1:0]  inboundData,
  input  logic [NUM_REGS*24-1:0] flipMask
);

  logic      sclS, sclPrev, sdaS, sdaPrev;
  logic [7:0] rdByte;
  rbStrobe_t strb;

  i2c_rb_linesync #(.STAGES(SYNC_LEN)) u_sclSync (
    .clk(clk), .rstN(rstN), .lineIn(sclIn), .lineS(sclS), .linePrev(sclPrev));

  i2c_rb_linesync #(.STAGES(SYNC_LEN)) u_sdaSync (
    .clk(clk), .rstN(rstN), .lineIn(sdaIn), .lineS(sdaS), .linePrev(sdaPrev));

  i2c_rb_ctrl #(.NUM_REGS(NUM_REGS), .DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclS(sclS), .sclPrev(sclPrev), .sdaS(sdaS),
    .sdaPrev(sdaPrev), .rdByte(rdByte), .strb(strb), .sdaOe(sdaOutEn));

  i2c_rb_datapath #(.NUM_REGS(NUM_REGS), .RESET_VAL(RESET_VAL)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .flipMask(flipMask),
    .outboundData(outboundData), .inboundData(inboundData), .rdByte(rdByte));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |=> (!sdaOutEn && inboundData == {NUM_REGS{RESET_VAL}}));

endmodule

// File: tb/tmr_i2c_regbank_tb.sv
module tmr_i2c_regbank_tb;

  localparam int         NR  = 3;
  localparam logic [6:0] DEV = 7'h52;
  localparam int         Q   = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          tbScl = 1'b1;
  logic          tbSda = 1'b1;
  logic          sdaOutEn;
  logic          sdaBus;
  logic [7:0]    tbStatus = 8'h00;
  logic [NR*8-1:0]  inboundData;
  logic [NR*8-1:0]  outboundData;
  logic [NR*24-1:0] tbFlip = '0;
  logic [7:0]    expV [NR];

  int  checks = 0;
  int  failures = 0;
  int  oeViol = 0;
  bit  done = 0;
  logic prevOe = 1'b0;

  always #5 clk = ~clk;

  assign sdaBus       = tbSda & ~sdaOutEn;
  assign outboundData = {tbStatus, inboundData[15:0]};

  tmr_i2c_regbank #(.NUM_REGS(NR), .DEV_ADDR(DEV)) u_dut (
    .clk(clk), .rstN(rstN), .sclIn(tbScl), .sdaIn(sdaBus), .sdaOutEn(sdaOutEn),
    .outboundData(outboundData), .inboundData(inboundData), .flipMask(tbFlip));

  always @(negedge clk) begin
    if (rstN && sdaOutEn !== prevOe && tbScl) oeViol++;
    prevOe = sdaOutEn;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2cStart();
    tbSda = 1'b1; waitQ();
    tbScl = 1'b1; waitQ();
    tbSda = 1'b0; waitQ();
    tbScl = 1'b0; waitQ();
  endtask

  task automatic i2cStop();
    tbSda = 1'b0; waitQ();
    tbScl = 1'b1; waitQ();
    tbSda = 1'b1; waitQ(); waitQ();
  endtask

  task automatic sendBit(input logic b);
    tbSda = b; waitQ();
    tbScl = 1'b1; waitQ(); waitQ();
    tbScl = 1'b0; waitQ();
  endtask

  task automatic getBit(output logic b);
    tbSda = 1'b1; waitQ();
    tbScl = 1'b1; waitQ();
    b = sdaBus; waitQ();
    tbScl = 1'b0; waitQ();
  endtask

  task automatic wrByte(input logic [7:0] v, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
    getBit(b);
    acked = ~b;
  endtask

  task automatic rdByte(input logic hostAck, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      getBit(b);
      v[i] = b;
    end
    sendBit(~hostAck);
  endtask

  function automatic logic [7:0] inb(input int r);
    return inboundData[r*8 +: 8];
  endfunction

  task automatic checkAllRegs(input string tag);
    for (int r = 0; r < NR; r++) chk(tag, int'(inb(r)), int'(expV[r]));
  endtask

  initial begin
    logic       a;
    logic [7:0] d;
    logic [7:0] v0, v1, v2;

    for (int r = 0; r < NR; r++) expV[r] = 8'h00;
    repeat (4) @(negedge clk);
    // R1: held in reset
    checkAllRegs("R1 reset value");
    chk("R1 sda released", int'(sdaOutEn), 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    checkAllRegs("R1 after reset");

    for (int p = 0; p < 16; p++) begin
      v0 = 8'((p * 37 + 11) & 255);
      v1 = 8'((p * 91 + 200) & 255);
      v2 = 8'((p * 29) ^ 8'hA5);
      tbStatus = 8'((p * 53 + 7) & 255);
      i2cStart();
      wrByte({DEV, 1'b0}, a); chk("R2 own address ack", int'(a), 1);
      wrByte(8'h00, a);       chk("R3 regaddr ack", int'(a), 1);
      wrByte(v0, a);          chk("R3 data ack", int'(a), 1);
      wrByte(v1, a);          chk("R3 data ack", int'(a), 1);
      wrByte(v2, a);          chk("R3 data ack", int'(a), 1);
      i2cStop();
      expV[0] = v0; expV[1] = v1; expV[2] = v2;
      checkAllRegs("R3 burst write");
      // R9: pointer write, repeated start, read
      i2cStart();
      wrByte({DEV, 1'b0}, a);
      wrByte(8'h00, a);
      i2cStart();
      wrByte({DEV, 1'b1}, a); chk("R9 read address ack after Sr", int'(a), 1);
      rdByte(1'b1, d); chk("R5 R9 read loc0", int'(d), int'(v0));
      rdByte(1'b1, d); chk("R5 read loc1", int'(d), int'(v1));
      rdByte(1'b0, d); chk("R5 read status loc2", int'(d), int'(tbStatus));
      chk("R5 sda released after nack", int'(sdaOutEn), 0);
      i2cStop();
    end

    // R3: write wraps from last location to 0
    i2cStart();
    wrByte({DEV, 1'b0}, a);
    wrByte(8'h02, a);
    wrByte(8'h3C, a);
    wrByte(8'hC3, a); chk("R3 ack after wrap", int'(a), 1);
    i2cStop();
    expV[2] = 8'h3C; expV[0] = 8'hC3;
    checkAllRegs("R3 pointer wrap write");

    // R5: read wraps from last location to 0
    tbStatus = 8'h9D;
    i2cStart();
    wrByte({DEV, 1'b0}, a);
    wrByte(8'h02, a);
    i2cStart();
    wrByte({DEV, 1'b1}, a);
    rdByte(1'b1, d); chk("R5 read last loc", int'(d), 8'h9D);
    rdByte(1'b0, d); chk("R5 read wrapped to loc0", int'(d), 8'hC3);
    chk("R5 sda released", int'(sdaOutEn), 0);
    i2cStop();

    // R2: foreign device addresses
    i2cStart();
    wrByte({DEV ^ 7'h01, 1'b0}, a); chk("R2 foreign address nack", int'(a), 0);
    wrByte(8'h00, a);               chk("R2 no ack after foreign", int'(a), 0);
    wrByte(8'h77, a);               chk("R2 no ack after foreign", int'(a), 0);
    i2cStop();
    checkAllRegs("R2 foreign write ignored");
    i2cStart();
    wrByte({DEV ^ 7'h40, 1'b1}, a); chk("R2 foreign read nack", int'(a), 0);
    chk("R2 sda idle", int'(sdaOutEn), 0);
    i2cStop();

    // R4: out-of-range register addresses; pointer now 1
    for (int t = 0; t < 2; t++) begin
      i2cStart();
      wrByte({DEV, 1'b0}, a);
      wrByte((t == 0) ? 8'h03 : 8'hFF, a); chk("R4 out-of-range nack", int'(a), 0);
      wrByte(8'h11, a);                    chk("R4 data nack", int'(a), 0);
      i2cStop();
      checkAllRegs("R4 data ignored");
    end
    i2cStart();
    wrByte({DEV, 1'b1}, a);
    rdByte(1'b0, d); chk("R4 pointer unchanged", int'(d), int'(expV[1]));
    i2cStop();

    // R6/R7: upset sweep over every location, copy and bit
    for (int r = 0; r < NR; r++) begin
      for (int c = 0; c < 3; c++) begin
        for (int b = 0; b < 8; b++) begin
          tbFlip[(c * NR + r) * 8 + b] = 1'b1;
          @(negedge clk);
          tbFlip = '0;
          chk("R6 single upset masked", int'(inb(r)), int'(expV[r]));
          @(negedge clk);
          tbFlip[(((c + 1) % 3) * NR + r) * 8 + b] = 1'b1;
          @(negedge clk);
          tbFlip = '0;
          chk("R7 second upset after scrub", int'(inb(r)), int'(expV[r]));
          repeat (3) @(negedge clk);
          chk("R7 settled", int'(inb(r)), int'(expV[r]));
        end
      end
    end

    // R8
    chk("R8 sda changes only with scl low", oeViol, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule